// File: doc/BRIEF.md
# On-Time Current Averaging Sampler

This block turns a stream of digitised current-sense samples into one average value for each conduction pulse of a switching converter. When the pulse-active input rises, a blanking window of a programmable number of clock cycles opens first. Samples arriving in that window are discarded, so the switching spike at turn-on never reaches the average. From the end of the window until the pulse ends, every valid sample is added into a running sum, and the accepted samples are counted.

When the pulse ends, the sum is divided by the count. A count that is a power of two takes a single-cycle shift. Any other count goes through a bit-serial restoring divider. The quotient is multiplied by four, clipped at full scale, and loaded into a held output register, with a one-cycle update strobe. Between pulses the output keeps its value. Samples that arrive while the pulse is inactive play no part.

Because nothing is sampled during the off-time, the output matches the true average only when the inductor current flows continuously. With discontinuous current it reads half the peak value. Downstream logic, such as an average current-limit loop, reads the held output and its strobe.

Top module: `pulse_avg_sense`

## Requirements
- R1: While `rst_n` is low at a rising edge, `avg_out` becomes 0 and `avg_upd` becomes 0.
- R2: Cycle index 0 is the first cycle in which `pulse_on` is high. `blank_len` is sampled in that cycle. Samples at indices below `blank_len` are discarded, whatever `sense_vld` says.
- R3: From index `blank_len` until `pulse_on` falls, each cycle with `sense_vld` high adds `sense_data` to the pulse's sum and increments its count. Cycles with `sense_vld` low add nothing.
- R4: Samples presented while `pulse_on` is low have no effect on any later result.
- R5: After a pulse with N > 0 accepted samples of sum S, `avg_out` becomes min(4·floor(S/N), 2^DW−1).
- R6: `avg_out` changes only in a cycle where `avg_upd` is high. `avg_upd` is high for exactly one cycle per updating pulse.
- R7: `avg_upd` rises no later than DW+CW+3 rising edges after the first cycle with `pulse_on` low.
- R8: A pulse that ends with zero accepted samples raises no `avg_upd`, and `avg_out` keeps its previous value.
- R9: At most 2^CW−1 samples are accepted per pulse. Further valid samples in the same pulse are ignored.
- R10: Each pulse's sum and count start from zero, independent of earlier pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| sense_data | input | DW | Unsigned current-sense sample |
| sense_vld | input | 1 | Qualifies `sense_data` in this cycle |
| pulse_on | input | 1 | High while the output pulse is active |
| blank_len | input | BW | Blanking length in cycles, sampled at pulse start |
| avg_out | output | DW | Held result: four times the on-time average, saturated |
| avg_upd | output | 1 | One-cycle strobe marking a new `avg_out` |

## Verification
The bench builds the block with DW=8, CW=4 and BW=3, with the power-of-two shortcut enabled. These small widths let the sweep cover every blanking length against pulse lengths from 1 to 12 cycles. They also let a single pulse reach the 15-sample capacity limit, and make saturation appear as soon as the average reaches 64. Sample counts of 1, 2, 4 and 8 take the shift path, while all other counts go through the serial divider, so the sweep exercises both latencies. Valid garbage samples are driven through every off-time, so any leak into the next result is caught.

// File: rtl/pavg_pkg.sv
// Shared types and helpers for the on-time current averaging sampler.
// Assumes: arguments to floor_log2 fit in 32 bits.
package pavg_pkg;

    // Divider sequencing states.
    typedef enum logic [1:0] {
        DIV_IDLE = 2'd0,
        DIV_RUN  = 2'd1,
        DIV_DONE = 2'd2
    } div_state_e;

    // Position of the highest set bit (0 for an argument of 0).
    function automatic int unsigned floor_log2(input logic [31:0] v);
        int unsigned r;
        r = 0;
        for (int i = 0; i < 32; i++) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/pavg_blank.sv
// Pulse edge detection and leading-edge blanking window.
// open_o is high in every pulse cycle whose index (0 = first high cycle)
// is at least the blank_len value sampled in the first cycle.
// Assumes: pulse_on is synchronous to clk.
module pavg_blank #(
    parameter int BW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pulse_on,
    input  logic [BW-1:0] blank_len,
    output logic          rise_o,
    output logic          fall_o,
    output logic          open_o
);
    logic          pulse_q;
    logic [BW-1:0] rem_q;
    logic [BW-1:0] rem_now;

    assign rise_o  = pulse_on & ~pulse_q;
    assign fall_o  = ~pulse_on & pulse_q;
    assign rem_now = rise_o ? blank_len : rem_q;
    assign open_o  = pulse_on & (rem_now == '0);

    // Registers the pulse level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= pulse_on;
    end

    // Counts down the remaining blanked cycles of the current pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)                          rem_q <= '0;
        else if (!pulse_on)                  rem_q <= '0;
        else if (rem_now != '0)              rem_q <= rem_now - 1'b1;
    end

    // R2 R3: once opened, the window stays open until the pulse ends
    window_stays_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_o |=> (open_o || !pulse_on));

endmodule

// File: rtl/pavg_acc.sv
// Per-pulse sum and count of accepted sense samples.
// The sum and count restart at each pulse start and stop growing once
// the count reaches its maximum value.
// Assumes: open_i is low outside pulses.
module pavg_acc #(
    parameter int DW = 10,
    parameter int CW = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    input  logic             open_i,
    input  logic             sense_vld,
    input  logic [DW-1:0]    sense_data,
    output logic [DW+CW-1:0] sum_o,
    output logic [CW-1:0]    cnt_o
);
    localparam int SW = DW + CW;
    localparam logic [CW-1:0] CMAX = '1;

    logic [SW-1:0] sum_q;
    logic [CW-1:0] cnt_q;
    logic [SW-1:0] base_sum;
    logic [CW-1:0] base_cnt;
    logic          take;

    assign base_sum = rise_i ? '0 : sum_q;
    assign base_cnt = rise_i ? '0 : cnt_q;
    assign take     = open_i & sense_vld & (base_cnt != CMAX);
    assign sum_o    = sum_q;
    assign cnt_o    = cnt_q;

    // Adds an accepted sample to the running sum and count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
            cnt_q <= '0;
        end else begin
            sum_q <= base_sum + (take ? {{CW{1'b0}}, sense_data} : '0);
            cnt_q <= base_cnt + {{(CW-1){1'b0}}, take};
        end
    end

    // R9: a full count never wraps; it only holds or restarts
    cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CMAX) |=> ((cnt_q == CMAX) || (cnt_q <= CW'(1))));

endmodule

// File: rtl/pavg_div.sv
// Unsigned divider for the pulse average. A start loads the operands.
// When FAST is set and the divisor is a power of two, the quotient is
// ready after one edge. Otherwise a restoring divider retires one quotient
// bit per cycle over NW cycles. done_o is high for one cycle.
// Assumes: den is nonzero at start; a new start aborts any run in progress.
module pavg_div
    import pavg_pkg::*;
#(
    parameter int NW   = 16,
    parameter int CW   = 6,
    parameter int QW   = 10,
    parameter bit FAST = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [NW-1:0] num,
    input  logic [CW-1:0] den,
    output logic          done_o,
    output logic [QW-1:0] quo_o
);
    localparam int NCW = $clog2(NW + 1);

    div_state_e     st;
    logic [NW-1:0]  q_q;
    logic [CW:0]    r_q;
    logic [CW-1:0]  d_q;
    logic [NCW-1:0] n_q;
    logic [CW:0]    r_sh;
    logic           ge;
    logic [CW:0]    r_nx;
    logic [NW-1:0]  q_nx;
    logic           fast_hit;
    logic [NW-1:0]  fast_q;

    // One restoring step: shift in the next dividend bit, subtract if it fits.
    always_comb begin
        r_sh = {r_q[CW-1:0], q_q[NW-1]};
        ge   = (r_sh >= {1'b0, d_q});
        r_nx = ge ? (r_sh - {1'b0, d_q}) : r_sh;
        q_nx = {q_q[NW-2:0], ge};
    end

    assign fast_q = num >> floor_log2({{(32-CW){1'b0}}, den});

    generate
        if (FAST) begin : g_shift_path
            assign fast_hit = (den != '0) && ((den & (den - 1'b1)) == '0);
        end else begin : g_serial_only
            assign fast_hit = 1'b0;
        end
    endgenerate

    // Sequences load, iteration and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= DIV_IDLE;
            q_q <= '0;
            r_q <= '0;
            d_q <= '0;
            n_q <= '0;
        end else if (start) begin
            d_q <= den;
            r_q <= '0;
            if (fast_hit) begin
                q_q <= fast_q;
                st  <= DIV_DONE;
            end else begin
                q_q <= num;
                n_q <= NCW'(NW);
                st  <= DIV_RUN;
            end
        end else begin
            case (st)
                DIV_RUN: begin
                    q_q <= q_nx;
                    r_q <= r_nx;
                    n_q <= n_q - 1'b1;
                    if (n_q == NCW'(1)) st <= DIV_DONE;
                end
                DIV_DONE: st <= DIV_IDLE;
                default:  st <= DIV_IDLE;
            endcase
        end
    end

    assign done_o = (st == DIV_DONE);
    assign quo_o  = q_q[QW-1:0];

    // R5: an average never exceeds the sample range
    quo_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (q_q[NW-1:QW] == '0));

    // R7: a start always leads into work or a result on the next cycle
    start_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (st != DIV_IDLE));

    // R5: the serial path never runs with a zero divisor
    div_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == DIV_RUN) |-> (d_q != '0));

endmodule

// File: rtl/pulse_avg_sense.sv
// On-time current averaging sampler, top level.
// Blanks the start of each pulse, accumulates valid samples until the pulse
// ends, divides by the count, scales by four with saturation and holds the
// result with a one-cycle update strobe.
// Assumes: pulses are spaced at least DW+CW+3 cycles apart, falling edge to
// falling edge, so that each result is delivered before the next divide starts.
module pulse_avg_sense #(
    parameter int DW   = 10,
    parameter int CW   = 6,
    parameter int BW   = 4,
    parameter bit FAST = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] sense_data,
    input  logic          sense_vld,
    input  logic          pulse_on,
    input  logic [BW-1:0] blank_len,
    output logic [DW-1:0] avg_out,
    output logic          avg_upd
);
    localparam int SW = DW + CW;
    localparam logic [DW-1:0] FULL    = '1;
    localparam logic [DW-1:0] SAT_LIM = FULL >> 2;

    logic          blk_rise;
    logic          blk_fall;
    logic          blk_open;
    logic [SW-1:0] acc_sum;
    logic [CW-1:0] acc_cnt;
    logic          div_start;
    logic          div_done;
    logic [DW-1:0] div_quo;
    logic [DW-1:0] scaled;
    logic [DW-1:0] avg_q;
    logic          upd_q;

    pavg_blank #(.BW(BW)) u_blank (
        .clk       (clk),
        .rst_n     (rst_n),
        .pulse_on  (pulse_on),
        .blank_len (blank_len),
        .rise_o    (blk_rise),
        .fall_o    (blk_fall),
        .open_o    (blk_open)
    );

    pavg_acc #(.DW(DW), .CW(CW)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (blk_rise),
        .open_i     (blk_open),
        .sense_vld  (sense_vld),
        .sense_data (sense_data),
        .sum_o      (acc_sum),
        .cnt_o      (acc_cnt)
    );

    assign div_start = blk_fall & (acc_cnt != '0);

    pavg_div #(.NW(SW), .CW(CW), .QW(DW), .FAST(FAST)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (div_start),
        .num    (acc_sum),
        .den    (acc_cnt),
        .done_o (div_done),
        .quo_o  (div_quo)
    );

    // Multiplies the average by four, clipping at full scale.
    always_comb begin
        if (div_quo > SAT_LIM) scaled = FULL;
        else                   scaled = {div_quo[DW-3:0], 2'b00};
    end

    // Holds the scaled result and raises the update strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            avg_q <= '0;
            upd_q <= 1'b0;
        end else begin
            upd_q <= div_done;
            if (div_done) avg_q <= scaled;
        end
    end

    assign avg_out = avg_q;
    assign avg_upd = upd_q;

    // R6
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !avg_upd |-> $stable(avg_out));

    // R4
    offtime_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse_on |=> $stable(acc_cnt));

    // R2
    blank_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_rise && (blank_len != '0)) |=> (acc_cnt == '0));

    // R8
    empty_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_fall && (acc_cnt == '0)) |=> !div_done);

endmodule

// File: tb/sim_pulse_avg_sense.sv
// Self-checking bench: sweeps blanking length and pulse length, then probes
// saturation, the capacity limit and pulse independence.
module sim_pulse_avg_sense;
    localparam int CLK_P = 10;
    localparam int DW = 8;
    localparam int CW = 4;
    localparam int BW = 3;
    localparam int CAP = (1 << CW) - 1;
    localparam int FULLV = (1 << DW) - 1;
    localparam int LAT_MAX = DW + CW + 3;
    localparam int GAP = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] sense_data = '0;
    logic          sense_vld = 1'b0;
    logic          pulse_on = 1'b0;
    logic [BW-1:0] blank_len = '0;
    logic [DW-1:0] avg_out;
    logic          avg_upd;

    int n_checks = 0;
    int n_fail = 0;
    int exp_hold = 0;
    int last_out = 0;
    int strobes = 0;
    int hold_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    pulse_avg_sense #(.DW(DW), .CW(CW), .BW(BW), .FAST(1'b1)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .sense_data (sense_data),
        .sense_vld  (sense_vld),
        .pulse_on   (pulse_on),
        .blank_len  (blank_len),
        .avg_out    (avg_out),
        .avg_upd    (avg_upd)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Observes outputs once per cycle, tracking strobes and unflagged changes.
    task automatic observe();
        if (int'(avg_out) != last_out && !avg_upd) hold_bad++;
        if (avg_upd) strobes++;
        last_out = int'(avg_out);
    endtask

    // mode 0: patterned data and valid; mode 1: constant cval, always valid;
    // mode 2: 10 until the capacity is reached, then 200, always valid.
    task automatic run_pulse(input int bl, input int len, input int mode,
                             input int cval, input string tag);
        int sum;
        int cnt;
        int lat;
        int exp;
        bit v;
        int d;
        sum = 0; cnt = 0; lat = -1; strobes = 0; hold_bad = 0;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            observe();
            case (mode)
                0: begin d = (k*37 + bl*11 + len*5) % 256; v = ((k + bl) % 3) != 2; end
                1: begin d = cval; v = 1'b1; end
                default: begin d = (cnt < CAP) ? 10 : 200; v = 1'b1; end
            endcase
            pulse_on   = 1'b1;
            sense_data = DW'(d);
            sense_vld  = v;
            blank_len  = BW'(bl);
            if (k >= bl && v && cnt < CAP) begin
                sum += d;
                cnt++;
            end
        end
        @(negedge clk);
        observe();
        pulse_on   = 1'b0;
        sense_vld  = 1'b1;
        sense_data = DW'(FULLV);
        for (int j = 1; j <= GAP; j++) begin
            @(negedge clk);
            observe();
            if (avg_upd && lat < 0) lat = j;
            sense_vld  = j[0];
            sense_data = DW'(j * 13);
            blank_len  = BW'(j);
        end
        if (cnt > 0) begin
            exp = (sum / cnt) * 4;
            if (exp > FULLV) exp = FULLV;
            exp_hold = exp;
        end
        check(int'(avg_out) == exp_hold, {tag, " R5 value"}, int'(avg_out), exp_hold);
        check(strobes == ((cnt > 0) ? 1 : 0), {tag, " R6/R8 strobe count"},
              strobes, (cnt > 0) ? 1 : 0);
        check(hold_bad == 0, {tag, " R6 change without strobe"}, hold_bad, 0);
        if (cnt > 0)
            check(lat >= 1 && lat <= LAT_MAX, {tag, " R7 latency"}, lat, LAT_MAX);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check(avg_out == '0, "R1 avg_out in reset", int'(avg_out), 0);
        check(avg_upd == 1'b0, "R1 avg_upd in reset", int'(avg_upd), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(avg_out == '0 && avg_upd == 1'b0, "R1 after release",
              int'(avg_out), 0);
        last_out = int'(avg_out);

        // R2 R3 R4 R8 R10: every blanking length against pulse lengths 1..12
        for (int bl = 0; bl < (1 << BW); bl++) begin
            for (int len = 1; len <= 12; len++) begin
                run_pulse(bl, len, 0, 0, "R2/R3/R4/R10 sweep");
            end
        end

        // R5: saturation boundary
        run_pulse(2, 7, 1, 63, "R5 below limit");
        run_pulse(2, 7, 1, 64, "R5 at limit");
        run_pulse(0, 5, 1, 255, "R5 full scale");
        // R10: a small pulse right after a full-scale one
        run_pulse(1, 4, 1, 5, "R10 fresh start");
        // R9: capacity limit, later samples ignored
        run_pulse(0, 30, 2, 0, "R9 capacity");
        // R8: everything blanked keeps the previous value
        run_pulse(7, 6, 1, 200, "R8 all blanked");

        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R7 watchdog actual=hung expected=complete");
        finish_run();
    end

endmodule